// File: doc/BRIEF.md
# Grayscale Framebuffer Scanout with Magnification

This block walks a packed 4-bit-per-pixel display memory and turns it into a stream of host pixels. It shows a window of 128×64 source pixels. Each source pixel is widened by a magnification factor in both directions, so with the default settings one frame is 512×256 output pixels. Each gray level is expanded by bit replication into one of three host formats: 15-bit RGB, 16-bit RGB or 24-bit gray.

A frame is requested with `start_i`. It runs only if the redraw flag is set. `invalidate_i` sets that flag, and starting a frame clears it. For each output line the block reads one memory byte at a time through a read port with one cycle of latency. The byte is held in a register and two pixels are taken from it, high nibble first. Each output line re-reads its source row, so no line is buffered. Pixels leave on a valid/ready port with end-of-line and end-of-frame markers.

Top module: `gray_scanout`

## Requirements
- R1: The redraw flag is clear after reset. `start_i` while idle with the flag set begins a frame and clears the flag. `start_i` with the flag clear starts nothing: `busy_o` and `pix_valid_o` stay low.
- R2: `invalidate_i` sets the redraw flag in any state, including mid-frame, so that a later `start_i` runs a frame.
- R3: Reads address only source rows 0 to SRC_ROWS-1 (default 64 of 80). Byte `b` of row `r` is read at `r*SRC_BYTES + b`, with SRC_BYTES defaulting to 64.
- R4: Within a byte, bits [7:4] are the left pixel and bits [3:0] are the right pixel.
- R5: Each source pixel is emitted MAG times in a row (default 4), and each source row yields MAG identical output lines. A frame is exactly SRC_BYTES*2*MAG by SRC_ROWS*MAG pixels.
- R6: With `fmt_i`=0 (15-bit RGB), gray level i gives n = 2i + (i>>3). The output is n in bits [14:10], [9:5] and [4:0], and all other bits are zero.
- R7: With `fmt_i`=1 (16-bit RGB), n sits in bits [15:11] and [4:0]. Bits [10:5] hold {n, n[4]}, and bits [23:16] are zero.
- R8: With `fmt_i`=2 or 3 (gray), g = (i<<4)|i is placed in bits [23:16], [15:8] and [7:0].
- R9: `fmt_i` is sampled when a frame starts. Changing it during a frame has no effect on that frame.
- R10: While `pix_valid_o` is high and `pix_ready_i` is low, `pix_valid_o`, `pix_data_o`, `pix_eol_o` and `pix_eof_o` hold their values.
- R11: `pix_eol_o` marks the last pixel of every output line. `pix_eof_o` marks only the last pixel of the frame, and always together with `pix_eol_o`.
- R12: `busy_o` rises on the cycle after a frame starts and falls on the cycle after the final pixel is accepted. `pix_valid_o` is high only while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| invalidate_i | input | 1 | Sets the redraw flag |
| start_i | input | 1 | Frame request, honoured when idle with the flag set |
| fmt_i | input | 2 | Output format: 0 RGB15, 1 RGB16, 2/3 gray24 |
| busy_o | output | 1 | A frame is in progress |
| ram_rd_o | output | 1 | Memory read strobe |
| ram_addr_o | output | ADDR_W | Memory byte address |
| ram_data_i | input | 8 | Read data, valid one cycle after the strobe |
| pix_data_o | output | 24 | Expanded pixel, 16-bit formats zero-extended |
| pix_valid_o | output | 1 | Pixel available |
| pix_ready_i | input | 1 | Sink accepts the pixel |
| pix_eol_o | output | 1 | Last pixel of an output line |
| pix_eof_o | output | 1 | Last pixel of the frame |

## Verification
The hardest condition to reach from the ports is a redraw request that arrives while a frame is already streaming. It must survive the frame, while the format change made at the same moment must not affect it. The stimulus pulses `invalidate_i` and flips `fmt_i` halfway through a frame that runs under random back-pressure. It then issues `start_i` with no new invalidate and expects a second full frame. A third start must produce nothing. A memory filled with alternating 0xF0/0x0F bytes covers gray levels 0 and 15 in every format, and stall cycles are checked for held outputs.

// File: rtl/gs_pkg.sv
package gs_pkg;

    typedef enum logic [1:0] {
        FMT_RGB15  = 2'd0,
        FMT_RGB16  = 2'd1,
        FMT_GRAY   = 2'd2,
        FMT_GRAY_B = 2'd3
    } pix_fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_CAPT  = 2'd2,
        ST_EMIT  = 2'd3
    } seq_state_e;

endpackage

// File: rtl/gs_expand.sv
module gs_expand
    import gs_pkg::*;
(
    input  pix_fmt_e    fmt_i,
    input  logic [3:0]  level_i,
    output logic [23:0] pixel_o
);
    logic [4:0] n5;
    logic [7:0] g8;

    always_comb begin
        n5 = {level_i, level_i[3]};
        g8 = {level_i, level_i};
        unique case (fmt_i)
            FMT_RGB15: pixel_o = {8'd0, 1'b0, n5, n5, n5};
            FMT_RGB16: pixel_o = {8'd0, n5, n5, n5[4], n5};
            default:   pixel_o = {g8, g8, g8};
        endcase
    end
endmodule

// File: rtl/gs_seq.sv
module gs_seq
    import gs_pkg::*;
#(
    parameter int SRC_BYTES = 64,
    parameter int SRC_ROWS  = 64,
    parameter int RAM_ROWS  = 80,
    parameter int MAG       = 4,
    localparam int ADDR_W   = $clog2(RAM_ROWS * SRC_BYTES),
    localparam int COL_W    = (SRC_BYTES > 1) ? $clog2(SRC_BYTES) : 1,
    localparam int ROW_W    = (SRC_ROWS > 1) ? $clog2(SRC_ROWS) : 1,
    localparam int MAG_W    = (MAG > 1) ? $clog2(MAG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              invalidate_i,
    input  logic              start_i,
    input  pix_fmt_e          fmt_i,
    input  logic              ready_i,
    input  logic [7:0]        ram_data_i,
    output logic              ram_rd_o,
    output logic [ADDR_W-1:0] ram_addr_o,
    output logic              busy_o,
    output logic              emit_o,
    output logic              eol_o,
    output logic              eof_o,
    output logic [3:0]        level_o,
    output pix_fmt_e          fmt_o
);
    typedef struct packed {
        seq_state_e       state;
        logic [ROW_W-1:0] row;
        logic [MAG_W-1:0] vrep;
        logic [COL_W-1:0] col;
        logic             half;
        logic [MAG_W-1:0] hrep;
        logic [7:0]       data;
        pix_fmt_e         fmt;
        logic             redraw;
    } seq_t;

    seq_t s_q, s_d;
    logic last_h, last_col, last_v, last_row;

    always_comb begin
        last_h   = (s_q.hrep == MAG_W'(MAG - 1));
        last_col = (s_q.col  == COL_W'(SRC_BYTES - 1));
        last_v   = (s_q.vrep == MAG_W'(MAG - 1));
        last_row = (s_q.row  == ROW_W'(SRC_ROWS - 1));

        s_d = s_q;
        unique case (s_q.state)
            ST_IDLE: begin
                if (start_i && s_q.redraw) begin
                    s_d.state  = ST_FETCH;
                    s_d.row    = '0;
                    s_d.vrep   = '0;
                    s_d.col    = '0;
                    s_d.half   = 1'b0;
                    s_d.hrep   = '0;
                    s_d.fmt    = fmt_i;
                    s_d.redraw = 1'b0;
                end
            end
            ST_FETCH: s_d.state = ST_CAPT;
            ST_CAPT: begin
                s_d.data  = ram_data_i;
                s_d.state = ST_EMIT;
            end
            ST_EMIT: begin
                if (ready_i) begin
                    if (!last_h) begin
                        s_d.hrep = s_q.hrep + 1'b1;
                    end else begin
                        s_d.hrep = '0;
                        if (!s_q.half) begin
                            s_d.half = 1'b1;
                        end else begin
                            s_d.half  = 1'b0;
                            s_d.state = ST_FETCH;
                            if (!last_col) begin
                                s_d.col = s_q.col + 1'b1;
                            end else begin
                                s_d.col = '0;
                                if (!last_v) begin
                                    s_d.vrep = s_q.vrep + 1'b1;
                                end else begin
                                    s_d.vrep = '0;
                                    if (!last_row) begin
                                        s_d.row = s_q.row + 1'b1;
                                    end else begin
                                        s_d.row   = '0;
                                        s_d.state = ST_IDLE;
                                    end
                                end
                            end
                        end
                    end
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
        if (invalidate_i) s_d.redraw = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{state: ST_IDLE, fmt: FMT_RGB15, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign ram_rd_o   = (s_q.state == ST_FETCH);
    assign ram_addr_o = ADDR_W'(s_q.row) * ADDR_W'(SRC_BYTES) + ADDR_W'(s_q.col);
    assign busy_o     = (s_q.state != ST_IDLE);
    assign emit_o     = (s_q.state == ST_EMIT);
    assign eol_o      = emit_o && last_h && s_q.half && last_col;
    assign eof_o      = eol_o && last_v && last_row;
    assign level_o    = s_q.half ? s_q.data[3:0] : s_q.data[7:4];
    assign fmt_o      = s_q.fmt;

    // R1: a start without a pending redraw leaves the sequencer idle
    a_r1_no_flag_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && s_q.state == ST_IDLE && !s_q.redraw) |=> (s_q.state == ST_IDLE));

    // R2: an invalidate always leaves the flag set
    a_r2_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        invalidate_i |=> s_q.redraw);

    // R9: the frame format is frozen while a frame runs
    a_r9_fmt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && s_q.state != ST_EMIT) |=> $stable(s_q.fmt) || !busy_o || $past(s_q.state) == ST_IDLE);
endmodule

// File: rtl/gray_scanout.sv
module gray_scanout
    import gs_pkg::*;
#(
    parameter int SRC_BYTES = 64,
    parameter int SRC_ROWS  = 64,
    parameter int RAM_ROWS  = 80,
    parameter int MAG       = 4,
    localparam int ADDR_W   = $clog2(RAM_ROWS * SRC_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              invalidate_i,
    input  logic              start_i,
    input  logic [1:0]        fmt_i,
    output logic              busy_o,
    output logic              ram_rd_o,
    output logic [ADDR_W-1:0] ram_addr_o,
    input  logic [7:0]        ram_data_i,
    output logic [23:0]       pix_data_o,
    output logic              pix_valid_o,
    input  logic              pix_ready_i,
    output logic              pix_eol_o,
    output logic              pix_eof_o
);
    logic [3:0] level;
    pix_fmt_e   frame_fmt;

    gs_seq #(
        .SRC_BYTES(SRC_BYTES),
        .SRC_ROWS (SRC_ROWS),
        .RAM_ROWS (RAM_ROWS),
        .MAG      (MAG)
    ) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .invalidate_i(invalidate_i),
        .start_i     (start_i),
        .fmt_i       (pix_fmt_e'(fmt_i)),
        .ready_i     (pix_ready_i),
        .ram_data_i  (ram_data_i),
        .ram_rd_o    (ram_rd_o),
        .ram_addr_o  (ram_addr_o),
        .busy_o      (busy_o),
        .emit_o      (pix_valid_o),
        .eol_o       (pix_eol_o),
        .eof_o       (pix_eof_o),
        .level_o     (level),
        .fmt_o       (frame_fmt)
    );

    gs_expand i_expand (
        .fmt_i  (frame_fmt),
        .level_i(level),
        .pixel_o(pix_data_o)
    );

    // R3: reads stay inside the shown rows
    a_r3_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
        ram_rd_o |-> (int'(ram_addr_o) < SRC_ROWS * SRC_BYTES));

    // R10: a stalled pixel is held unchanged
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid_o && !pix_ready_i) |=>
            (pix_valid_o && $stable(pix_data_o) && $stable(pix_eol_o) && $stable(pix_eof_o)));

    // R11: end of frame coincides with end of line
    a_r11_eof_eol: assert property (@(posedge clk) disable iff (!rst_n)
        pix_eof_o |-> (pix_eol_o && pix_valid_o));

    // R12: pixels only appear during a frame
    a_r12_valid_busy: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid_o |-> busy_o);
endmodule

// File: tb/test_gray_scanout.sv
module test_gray_scanout;
    localparam int CLK_PERIOD = 10;
    localparam int SB   = 8;
    localparam int SR   = 5;
    localparam int RR   = 7;
    localparam int MAGF = 4;
    localparam int AW   = $clog2(RR * SB);
    localparam int W    = SB * 2 * MAGF;
    localparam int H    = SR * MAGF;
    localparam int TOTAL = W * H;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic invalidate_i = 1'b0;
    logic start_i = 1'b0;
    logic [1:0] fmt_i = 2'd0;
    logic busy_o, ram_rd_o;
    logic [AW-1:0] ram_addr_o;
    logic [7:0] ram_data_i = 8'd0;
    logic [23:0] pix_data_o;
    logic pix_valid_o, pix_eol_o, pix_eof_o;
    logic pix_ready_i = 1'b0;

    logic [7:0] mem [RR * SB];
    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) if (ram_rd_o) ram_data_i <= mem[int'(ram_addr_o)];

    gray_scanout #(.SRC_BYTES(SB), .SRC_ROWS(SR), .RAM_ROWS(RR), .MAG(MAGF)) i_gray_scanout (
        .clk(clk), .rst_n(rst_n), .invalidate_i(invalidate_i), .start_i(start_i),
        .fmt_i(fmt_i), .busy_o(busy_o), .ram_rd_o(ram_rd_o), .ram_addr_o(ram_addr_o),
        .ram_data_i(ram_data_i), .pix_data_o(pix_data_o), .pix_valid_o(pix_valid_o),
        .pix_ready_i(pix_ready_i), .pix_eol_o(pix_eol_o), .pix_eof_o(pix_eof_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int expand(input int f, input int lvl);
        int n, g;
        n = 2 * lvl + (lvl >> 3);
        if (f == 0) return n | (n << 5) | (n << 10);
        if (f == 1) begin
            g = (n << 1) | (n >> 4);
            return (n << 11) | (g << 5) | n;
        end
        g = lvl * 17;
        return g * 32'h010101;
    endfunction

    function automatic string fmt_req(input int f);
        if (f == 0) return "R6";
        if (f == 1) return "R7";
        return "R8";
    endfunction

    task automatic expect_idle(input int n, input string req);
        bit seen = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            pix_ready_i = 1'b1;
            #1;
            if (busy_o || pix_valid_o) seen = 1'b1;
        end
        check(!seen, req, int'(seen), 0);
    endtask

    task automatic run_frame(input int f, input int dens, input bit poke);
        int cnt = 0;
        int guard = 0;
        bit held = 1'b0;
        logic [25:0] hold_v;
        @(negedge clk);
        fmt_i = 2'(f);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        #1;
        check(busy_o == 1'b1, "R12", int'(busy_o), 1);
        while (cnt < TOTAL && guard < 40 * TOTAL) begin
            @(negedge clk);
            invalidate_i = 1'b0;
            pix_ready_i = (($urandom % 100) < dens);
            #1;
            guard++;
            if (ram_rd_o && int'(ram_addr_o) >= SR * SB)
                check(1'b0, "R3", int'(ram_addr_o), SR * SB - 1);
            if (held)
                check(pix_valid_o && {pix_eol_o, pix_eof_o, pix_data_o} == hold_v,
                      "R10", int'(pix_data_o), int'(hold_v[23:0]));
            if (pix_valid_o && pix_ready_i) begin
                int x, y, px, b, lvl, e;
                bit eol, eof;
                x = cnt % W;
                y = cnt / W;
                px = x / MAGF;
                b = mem[(y / MAGF) * SB + px / 2];
                lvl = (px % 2 == 0) ? (b >> 4) : (b & 15);  // R4 high nibble left
                e = expand(f, lvl);
                eol = (x == W - 1);
                eof = eol && (y == H - 1);
                check(int'(pix_data_o) == e, fmt_req(f), int'(pix_data_o), e);
                check(pix_eol_o == eol && pix_eof_o == eof, "R11",
                      int'({pix_eol_o, pix_eof_o}), int'({eol, eof}));
                cnt++;
                held = 1'b0;
                if (poke && cnt == TOTAL / 2) begin
                    fmt_i = ~fmt_i;          // R9: ignored for this frame
                    invalidate_i = 1'b1;     // R2: mid-frame request
                end
            end else if (pix_valid_o) begin
                held = 1'b1;
                hold_v = {pix_eol_o, pix_eof_o, pix_data_o};
            end else begin
                held = 1'b0;
            end
        end
        check(cnt == TOTAL, "R5", cnt, TOTAL);
        @(negedge clk);
        invalidate_i = 1'b0;
        pix_ready_i = 1'b0;
        #1;
        check(!busy_o && !pix_valid_o, "R12", int'({busy_o, pix_valid_o}), 0);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete");
        summary();
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < RR * SB; i++) mem[i] = (i % 2 == 0) ? 8'hF0 : 8'h0F;
        repeat (3) @(negedge clk);
        #1;
        check(!busy_o && !pix_valid_o && !ram_rd_o, "R12",
              int'({busy_o, pix_valid_o, ram_rd_o}), 0);
        rst_n = 1'b1;

        // R1: no redraw pending after reset
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        expect_idle(24, "R1");

        // extremes 0 and 15 in every format
        for (int f = 0; f < 3; f++) begin
            @(negedge clk);
            invalidate_i = 1'b1;
            @(negedge clk);
            invalidate_i = 1'b0;
            run_frame(f, (f == 1) ? 70 : 100, 1'b0);
        end

        // random contents, mid-frame invalidate and format flip
        for (int i = 0; i < RR * SB; i++) mem[i] = 8'($urandom);
        @(negedge clk);
        invalidate_i = 1'b1;
        @(negedge clk);
        invalidate_i = 1'b0;
        run_frame(3, 50, 1'b1);
        // R2: pending flag from mid-frame invalidate allows this frame
        run_frame(0, 60, 1'b0);
        // R1: flag consumed, nothing runs
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        expect_idle(24, "R1");

        summary();
    end
endmodule